// File: doc/BRIEF.md
# Four-Wire Serial Register Port

This block is the slave side of a four-wire serial link that gives a host access to a bank of byte-wide configuration registers. The host uses four signals: an active-low select (`cs_n`), a serial clock (`sck`), data toward the block (`sdi`) and data back to the host (`sdo`). The return line is a tristate output, so it comes out as a data bit and an output enable. Each access is a command byte and then a payload byte. The command byte holds the direction and a 7-bit register address. The payload byte is either the value to store or the value returned. The two bytes may share one select window of sixteen clocks, or they may be sent in two separate windows of eight clocks each.

All three link inputs pass through a synchronizer into the system clock domain, and the block works on the edges it finds there. The register at address 0 is the configuration register. Writing a 1 to its top bit sets every register back to its reset value, as a hardware reset does, and pulses `soft_rst` for one cycle. Bit 6 of that register drives `lin_mode`, which selects 16-bit linear sample coding when it is set and companded coding when it is clear. The whole bank is also presented on `reg_image` for use by the rest of the chip.

Top module: `sreg_serial_port`

## Requirements
- R1: After reset, the configuration register (address 0) holds 3Fh, every other register holds 00h, `sdo_oe` is 0, `lin_mode` is 0 and `soft_rst` is 0.
- R2: Bits are taken MSB first on rising `sck` edges while `cs_n` is low. In the command byte, bit 7 = 1 requests a read, bit 7 = 0 requests a write, and bits 6..0 hold the register address.
- R3: `sdo_oe` stays 0 through the first eight clock pulses of the command byte, including the high half of the eighth pulse. In a read, `sdo` carries the returned byte MSB first and changes only on falling `sck` edges.
- R4: A write sent as sixteen clocks in one select window stores the payload byte into the addressed register.
- R5: If the select window closes after exactly eight command bits, the access stays pending and the next window carries the payload. In a pending read, `sdo_oe` rises and `sdo` shows bit 7 as soon as `cs_n` falls, before the first clock.
- R6: If `cs_n` rises after 1 to 7 bits of a byte, the access is dropped, no register changes, and the next window starts with a command byte.
- R7: Addresses at or above the register count (41 by default) are not implemented. Writes to them change nothing, and reads from them return 00h. Address 40 is the last implemented register.
- R8: Writing a byte with bit 7 set to address 0 sets all registers back to their R1 values and pulses `soft_rst` high for exactly one clock.
- R9: `lin_mode` equals bit 6 of the configuration register.
- R10: Clocks beyond the sixteenth in one window are ignored: they start no new access, and the following window works normally.
- R11: `sdo_oe` is 0 whenever the synchronized `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data toward the block |
| sdo | output | 1 | Serial data toward the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| reg_image | output | NUM_REGS*8 | All registers; register n sits at bits n*8+7..n*8 |
| soft_rst | output | 1 | One-cycle pulse when a soft reset is written |
| lin_mode | output | 1 | Linear (1) or companded (0) coding select |

## Verification
A change on a link input passes two synchronizer flops and is then seen as an edge. The frame engine registers its response on the third system clock edge after the change, so `sdo` and `sdo_oe` settle three cycles after a `sck` or `cs_n` edge. A stored register value appears one cycle later, when the write strobe reaches the bank. The bench holds each half of `sck` for thirteen system clocks. It samples `sdo` and `sdo_oe` on falling system-clock edges at the end of each half period, well after they have settled. It reads `reg_image` and `soft_rst` only after the window has closed and two more half periods have passed.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int CFG_ADDR  = 0;
    localparam logic [BYTE_W-1:0] CFG_RESET = 8'h3F;
    localparam int SRST_BIT  = 7;
    localparam int LIN_BIT   = 6;
    localparam int CNT_W     = $clog2(BYTE_W) + 1;

    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   rx;
        logic                rw;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   tx;
        logic                oe;
        logic                arm;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BYTE_W-1:0]   wr_data;
        logic                sck_p;
        logic                csn_p;
    } eng_s;

    localparam eng_s ENG_RESET = '{
        phase:   PH_CTRL,
        cnt:     '0,
        rx:      '0,
        rw:      1'b0,
        addr:    '0,
        tx:      '0,
        oe:      1'b0,
        arm:     1'b0,
        wr_en:   1'b0,
        wr_addr: '0,
        wr_data: '0,
        sck_p:   1'b0,
        csn_p:   1'b1
    };

endpackage

// File: rtl/sreg_sync_chain.sv
module sreg_sync_chain #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = din;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sreg_frame_engine.sv
module sreg_frame_engine
    import sreg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_l,
    input  logic              csn_l,
    input  logic              sdi_l,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    eng_s q, d;

    logic sck_rise, sck_fall, sel_start, sel_end, sel_act;
    logic [BYTE_W-1:0] rx_next;

    assign sck_rise  =  sck_l & ~q.sck_p;
    assign sck_fall  = ~sck_l &  q.sck_p;
    assign sel_end   =  csn_l & ~q.csn_p;
    assign sel_start = ~csn_l &  q.csn_p;
    assign sel_act   = ~csn_l;
    assign rx_next   = {q.rx[BYTE_W-2:0], sdi_l};

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.sck_p = sck_l;
        d.csn_p = csn_l;

        if (sel_end) begin
            // window closed: release the line, keep only a whole command byte
            d.oe  = 1'b0;
            d.arm = 1'b0;
            d.rx  = '0;
            d.cnt = '0;
            if (!(q.phase == PH_DATA && q.cnt == '0)) begin
                d.phase = PH_CTRL;
            end
        end else if (sel_start) begin
            // second window of a split read: drive bit 7 before any clock
            if (q.phase == PH_DATA && q.rw) begin
                d.tx = rd_data;
                d.oe = 1'b1;
            end
        end else if (sel_act) begin
            if (sck_rise && q.phase != PH_DONE) begin
                d.rx  = rx_next;
                d.cnt = CNT_W'(q.cnt + 1'b1);
                if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                    d.cnt = '0;
                    if (q.phase == PH_CTRL) begin
                        d.rw    = rx_next[BYTE_W-1];
                        d.addr  = rx_next[ADDR_W-1:0];
                        d.phase = PH_DATA;
                        d.arm   = rx_next[BYTE_W-1];
                    end else begin
                        d.phase = PH_DONE;
                        if (!q.rw) begin
                            d.wr_en   = 1'b1;
                            d.wr_addr = q.addr;
                            d.wr_data = rx_next;
                        end
                    end
                end
            end else if (sck_fall) begin
                if (q.arm) begin
                    d.tx  = rd_data;
                    d.oe  = 1'b1;
                    d.arm = 1'b0;
                end else if (q.oe) begin
                    d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RESET;
        else        q <= d;
    end

    assign rd_addr = q.addr;
    assign sdo     = q.tx[BYTE_W-1];
    assign sdo_oe  = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;

    // R3: the line is driven only for a read past its command byte
    a_r3_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.rw && q.phase != PH_CTRL));

    // R11: deselected link never drives
    a_r11_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        csn_l |=> !q.oe);

    // R4: a write strobe only follows a completed write payload
    a_r4_wr_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.phase == PH_DONE && !q.rw));

    // R6: closing a window in the command phase restarts the byte
    a_r6_drop_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_end && q.phase == PH_CTRL) |=> (q.phase == PH_CTRL && q.cnt == '0));

    // R10: after a full access the engine waits for the window to close
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DONE && !sel_end) |=> (q.phase == PH_DONE && !q.wr_en));

endmodule

// File: rtl/sreg_reg_bank.sv
module sreg_reg_bank
    import sreg_port_pkg::*;
#(
    parameter int NUM_REGS = 41
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] image,
    output logic                       soft_rst,
    output logic                       lin_mode
);

    logic [BYTE_W-1:0] dflt   [NUM_REGS];
    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic              srst_d, srst_q;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            if (g == CFG_ADDR) begin : g_cfg
                assign dflt[g] = CFG_RESET;
            end else begin : g_plain
                assign dflt[g] = '0;
            end
            assign image[g*BYTE_W +: BYTE_W] = regs_q[g];
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        srst_d = 1'b0;
        if (wr_en) begin
            if (int'(wr_addr) == CFG_ADDR && wr_data[SRST_BIT]) begin
                regs_d = dflt;
                srst_d = 1'b1;
            end else begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (int'(wr_addr) == i) regs_d[i] = wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(rd_addr) == i) rd_data = regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= dflt;
            srst_q <= 1'b0;
        end else begin
            regs_q <= regs_d;
            srst_q <= srst_d;
        end
    end

    assign soft_rst = srst_q;
    assign lin_mode = regs_q[CFG_ADDR][LIN_BIT];

    // R8: the cycle of the pulse shows the bank at its defaults
    a_r8_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> (regs_q[CFG_ADDR] == CFG_RESET && !lin_mode));

    // R8: pulse lasts a single cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);

    // R7: unimplemented addresses leave the bank untouched
    a_r7_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(image));

endmodule

// File: rtl/sreg_serial_port.sv
module sreg_serial_port
    import sreg_port_pkg::*;
#(
    parameter int NUM_REGS    = 41,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sck,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic [NUM_REGS*BYTE_W-1:0] reg_image,
    output logic                       soft_rst,
    output logic                       lin_mode
);

    localparam int LINK_W = 3;

    logic [LINK_W-1:0] link_raw, link_lvl;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    assign link_raw = {sdi, cs_n, sck};

    sreg_sync_chain #(
        .WIDTH   (LINK_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (link_raw),
        .dout  (link_lvl)
    );

    sreg_frame_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_l   (link_lvl[0]),
        .csn_l   (link_lvl[1]),
        .sdi_l   (link_lvl[2]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    sreg_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .image    (reg_image),
        .soft_rst (soft_rst),
        .lin_mode (lin_mode)
    );

endmodule

// File: tb/sreg_serial_port_bench.sv
module sreg_serial_port_bench;

    localparam int NREG = 41;
    localparam int HALF = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, soft_rst, lin_mode;
    logic [NREG*8-1:0] reg_image;

    int ntests = 0;
    int nfail  = 0;
    int srst_cycles = 0;

    always #5 clk = ~clk;

    sreg_serial_port #(.NUM_REGS(NREG)) u_sreg_serial_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .sdi       (sdi),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .reg_image (reg_image),
        .soft_rst  (soft_rst),
        .lin_mode  (lin_mode)
    );

    always @(negedge clk) if (soft_rst) srst_cycles++;

    function automatic logic [7:0] rb(input int a);
        return reg_image[a*8 +: 8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one select window of n bits; samples sdo/sdo_oe just before each rise
    task automatic window(input logic [23:0] bits, input int n,
                          output logic [23:0] rx, output logic [23:0] oe_v,
                          output logic oe_high8);
        rx = '0; oe_v = '0; oe_high8 = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdi = bits[n-1-i];
            wait_clk(HALF);
            rx   = {rx[22:0], sdo};
            oe_v = {oe_v[22:0], sdo_oe};
            sck  = 1'b1;
            wait_clk(HALF);
            if (i == 7) oe_high8 = sdo_oe;
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic wr16(input logic [6:0] a, input logic [7:0] v);
        logic [23:0] rx, oe; logic h8;
        window({8'h00, 1'b0, a, v}, 16, rx, oe, h8);
        check("R3 write oe during command", {oe[15:8], 7'd0, h8}, 32'h0);
    endtask

    task automatic rd16(input logic [6:0] a, output logic [7:0] v);
        logic [23:0] rx, oe; logic h8;
        window({8'h00, 1'b1, a, 8'h00}, 16, rx, oe, h8);
        check("R3 read oe low for first 8 pulses", {oe[15:8], 7'd0, h8}, 32'h0);
        check("R3 read oe high in payload", oe[7:0], 32'hFF);
        check("R11 oe low after window", sdo_oe, 1'b0);
        v = rx[7:0];
    endtask

    task automatic t_reset;
        check("R1 cfg reset", rb(0), 32'h3F);
        check("R1 reg5 reset", rb(5), 32'h00);
        check("R1 reg40 reset", rb(40), 32'h00);
        check("R1 sdo_oe reset", sdo_oe, 1'b0);
        check("R1 soft_rst reset", soft_rst, 1'b0);
        check("R9 lin_mode reset", lin_mode, 1'b0);
    endtask

    task automatic t_single;
        logic [7:0] v;
        wr16(7'h05, 8'hA5);
        check("R4 single write reg5", rb(5), 32'hA5);
        check("R2 no write to neighbour", rb(4), 32'h00);
        rd16(7'h05, v);
        check("R2 single read reg5", v, 32'hA5);
    endtask

    task automatic t_split;
        logic [23:0] rx, oe; logic h8;
        window({16'h0, 1'b0, 7'h12}, 8, rx, oe, h8);
        check("R5 pending write not yet stored", rb(18), 32'h00);
        window({16'h0, 8'h3C}, 8, rx, oe, h8);
        check("R5 split write reg18", rb(18), 32'h3C);
        window({16'h0, 1'b1, 7'h12}, 8, rx, oe, h8);
        check("R3 split command oe low", {oe[7:0], 7'd0, h8}, 32'h0);
        window(24'h0, 8, rx, oe, h8);
        check("R5 split read oe from first bit", oe[7:0], 32'hFF);
        check("R5 split read data", rx[7:0], 32'h3C);
        check("R11 oe low after split read", sdo_oe, 1'b0);
    endtask

    task automatic t_partial;
        logic [23:0] rx, oe; logic h8;
        window({19'h0, 5'b0_0001}, 5, rx, oe, h8);
        wr16(7'h07, 8'h55);
        check("R6 partial command dropped, next write ok", rb(7), 32'h55);
        window({16'h0, 1'b0, 7'h08}, 8, rx, oe, h8);
        window({20'h0, 4'hF}, 4, rx, oe, h8);
        check("R6 partial payload stores nothing", rb(8), 32'h00);
        wr16(7'h08, 8'h66);
        check("R6 next window is a command", rb(8), 32'h66);
    endtask

    task automatic t_range;
        logic [NREG*8-1:0] snap;
        logic [7:0] v;
        snap = reg_image;
        wr16(7'h50, 8'hFF);
        check("R7 oor write ignored", (reg_image == snap) ? 1 : 0, 1);
        rd16(7'h50, v);
        check("R7 oor read returns 0", v, 32'h00);
        wr16(7'h28, 8'h9A);
        check("R7 last register writable", rb(40), 32'h9A);
        rd16(7'h28, v);
        check("R7 last register readable", v, 32'h9A);
        wr16(7'h29, 8'h77);
        rd16(7'h29, v);
        check("R7 first unimplemented reads 0", v, 32'h00);
    endtask

    task automatic t_lin;
        logic [7:0] v;
        wr16(7'h00, 8'h40);
        check("R9 lin_mode set", lin_mode, 1'b1);
        rd16(7'h00, v);
        check("R9 cfg readback", v, 32'h40);
        wr16(7'h00, 8'h3F);
        check("R9 lin_mode clear", lin_mode, 1'b0);
    endtask

    task automatic t_extra;
        logic [23:0] rx, oe; logic h8;
        window({1'b0, 7'h09, 8'h11, 8'h22}, 24, rx, oe, h8);
        check("R10 first access stored", rb(9), 32'h11);
        wr16(7'h0A, 8'h77);
        check("R10 following window works", rb(10), 32'h77);
        check("R10 extra bits not a command", rb(34), 32'h00);
    endtask

    task automatic t_soft;
        srst_cycles = 0;
        wr16(7'h00, 8'hC0);
        check("R8 soft_rst one cycle", srst_cycles, 1);
        check("R8 cfg restored", rb(0), 32'h3F);
        check("R8 reg5 cleared", rb(5), 32'h00);
        check("R8 reg40 cleared", rb(40), 32'h00);
        check("R8 lin_mode cleared", lin_mode, 1'b0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset;
        t_single;
        t_split;
        t_partial;
        t_range;
        t_lin;
        t_extra;
        t_soft;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        wait_clk(200000);
        ntests++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule